// File: doc/BRIEF.md
# Self-Correcting Sixteen-State Controller Register

This block is a 16-state Moore controller. Its state is held in a 7-bit register protected by a single-error-correcting code. Each state index is stored as a codeword that differs from every other codeword in at least three bit positions. If a single register bit is upset, the stored value sits next to exactly one codeword. The next-state decode therefore recovers the intended state in the same cycle and writes a clean codeword back on the next clock, with no reset needed.

The code is a Hamming(7,4) code with the state index as its data bits. Sixteen codewords each have seven one-bit neighbours, and 16 × (7 + 1) = 128 = 2^7, so these sets cover the whole 7-bit space. Any register value, including one hit by a multi-bit upset, therefore decodes to some legal state. A one-cycle flag reports that a correction took place. A test port can XOR a mask into the value being written, so that upsets can be injected.

The example transition table has four rules, highest priority first:

- jump to the mirror state 15 − s;
- step up;
- step down;
- hold.

A synchronous clear overrides all of them.

Top module: `secfsm_core`

## Requirements
- R1: While rst_ni is low, code_o is 7'b0000000 (the codeword of state 0), state_o is 0 and corr_o is 0, without waiting for a clock edge.
- R2: When srst_i is high at a rising edge, the register loads the codeword of state 0. This overrides jump_i, adv_i, rev_i and any injection.
- R3: The codeword for index d = {d3,d2,d1,d0} places the data bits at code bits 2, 4, 5, 6 (d0, d1, d2, d3). The parity bits are bit0 = d0^d1^d3, bit1 = d0^d2^d3 and bit3 = d1^d2^d3. After an edge with no injection, code_o is always such a clean codeword.
- R4: If code_o differs from the codeword of state s in exactly one bit, state_o shows s in that same cycle, and the next transition is computed from s.
- R5: corr_o is high for exactly the one cycle that follows a cycle in which code_o was not a codeword; otherwise it is low.
- R6: With jump_i high and srst_i low, the next state is 15 − s, whatever adv_i and rev_i are.
- R7: With adv_i high and jump_i and srst_i low, the next state is s + 1 modulo 16 (15 goes to 0). This takes priority over rev_i.
- R8: With only rev_i high among the controls, the next state is s − 1 modulo 16 (0 goes to 15).
- R9: With no control high, the state holds.
- R10: With inj_en_i high and srst_i low, the register loads the next codeword XOR inj_mask_i. A zero mask changes nothing.
- R11: Every 7-bit register value decodes to a legal index. A two-bit error decodes to the codeword at distance one; for example, 7'b0000011 reads as state 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| srst_i | input | 1 | Synchronous clear to state 0 |
| jump_i | input | 1 | Go to mirror state 15 − s |
| adv_i | input | 1 | Step state up by one |
| rev_i | input | 1 | Step state down by one |
| inj_en_i | input | 1 | Apply the injection mask to the next write |
| inj_mask_i | input | 7 | Bits to flip in the written codeword |
| state_o | output | 4 | Corrected current state index |
| code_o | output | 7 | Raw state register contents |
| corr_o | output | 1 | One-cycle flag: a correction took place |

## Verification
The transition assertions are qualified on the absence of injection and synchronous clear in the cycle they examine. They rely on the register holding at most a single-bit error whenever a decoded index is compared with its predecessor. The clean-write assertion assumes that upsets reach the register only through the injection port. The stimulus therefore injects single-bit masks except in one directed two-bit case, and it always follows an injection with a cycle that has no injection. All inputs are held at known values during and after reset.

// File: rtl/secfsm_pkg.sv
`timescale 1ns/1ps
package secfsm_pkg;
  localparam int IDX_W  = 4;
  localparam int CODE_W = (1 << $clog2(IDX_W + $clog2(IDX_W) + 1)) - 1;
  localparam int SYN_W  = $clog2(CODE_W + 1);
  localparam int N_ST   = 1 << IDX_W;

  typedef logic [IDX_W-1:0]  idx_t;
  typedef logic [CODE_W-1:0] code_t;
  typedef logic [SYN_W-1:0]  syn_t;

  // position p = bit index + 1; powers of two carry parity
  function automatic logic is_par_pos(int p);
    return (p & (p - 1)) == 0;
  endfunction

  function automatic code_t encode(idx_t d);
    code_t c;
    int    k;
    c = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_par_pos(p)) begin
        c[p-1] = d[k];
        k++;
      end
    end
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_par_pos(p)) begin
        for (int b = 0; b < SYN_W; b++) begin
          if (((p >> b) & 1) == 1) c[(1 << b) - 1] = c[(1 << b) - 1] ^ c[p-1];
        end
      end
    end
    return c;
  endfunction

  function automatic syn_t syndrome(code_t c);
    syn_t s;
    s = '0;
    for (int i = 0; i < CODE_W; i++) begin
      if (c[i]) s = s ^ syn_t'(i + 1);
    end
    return s;
  endfunction

  function automatic idx_t extract(code_t c);
    idx_t d;
    int   k;
    d = '0;
    k = 0;
    for (int p = 1; p <= CODE_W; p++) begin
      if (!is_par_pos(p)) begin
        d[k] = c[p-1];
        k++;
      end
    end
    return d;
  endfunction
endpackage

// File: rtl/secfsm_decode.sv
`timescale 1ns/1ps
module secfsm_decode
  import secfsm_pkg::*;
(
  input  code_t code_i,
  output idx_t  idx_o,
  output logic  nbr_o,
  output code_t fixed_o
);
  syn_t syn;

  always_comb begin
    syn     = syndrome(code_i);
    nbr_o   = (syn != '0);
    fixed_o = code_i;
    if (nbr_o) fixed_o[int'(syn) - 1] = ~code_i[int'(syn) - 1];
    idx_o   = extract(fixed_o);
  end

  // perfect code: every word lands on a codeword
  always_comb begin
    AST_FIXED_IS_CODEWORD: assert (syndrome(fixed_o) == '0 || $isunknown(code_i)); // R11
  end
endmodule

// File: rtl/secfsm_next.sv
`timescale 1ns/1ps
module secfsm_next
  import secfsm_pkg::*;
(
  input  idx_t cur_i,
  input  logic jump_i,
  input  logic adv_i,
  input  logic rev_i,
  output idx_t nxt_o
);
  idx_t tbl_jump [N_ST];
  idx_t tbl_adv  [N_ST];
  idx_t tbl_rev  [N_ST];

  for (genvar s = 0; s < N_ST; s++) begin : g_tbl
    assign tbl_jump[s] = idx_t'(N_ST - 1 - s);
    assign tbl_adv[s]  = idx_t'((s + 1) % N_ST);
    assign tbl_rev[s]  = idx_t'((s + N_ST - 1) % N_ST);
  end

  always_comb begin
    if (jump_i)      nxt_o = tbl_jump[cur_i];
    else if (adv_i)  nxt_o = tbl_adv[cur_i];
    else if (rev_i)  nxt_o = tbl_rev[cur_i];
    else             nxt_o = cur_i;
  end
endmodule

// File: rtl/secfsm_core.sv
`timescale 1ns/1ps
module secfsm_core
  import secfsm_pkg::*;
(
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             srst_i,
  input  logic             jump_i,
  input  logic             adv_i,
  input  logic             rev_i,
  input  logic             inj_en_i,
  input  logic [CODE_W-1:0] inj_mask_i,
  output logic [IDX_W-1:0]  state_o,
  output logic [CODE_W-1:0] code_o,
  output logic             corr_o
);
  localparam code_t RST_CODE = encode(idx_t'(0));

  code_t code_q, code_fixed, code_d;
  idx_t  cur_idx, nxt_idx;
  logic  nbr, corr_q, inj_prev_q;

  secfsm_decode u_dec (
    .code_i (code_q),
    .idx_o  (cur_idx),
    .nbr_o  (nbr),
    .fixed_o(code_fixed)
  );

  secfsm_next u_nxt (
    .cur_i (cur_idx),
    .jump_i(jump_i),
    .adv_i (adv_i),
    .rev_i (rev_i),
    .nxt_o (nxt_idx)
  );

  always_comb begin
    code_d = encode(nxt_idx);
    if (inj_en_i) code_d = code_d ^ inj_mask_i;
    if (srst_i)   code_d = RST_CODE;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      code_q     <= RST_CODE;
      corr_q     <= 1'b0;
      inj_prev_q <= 1'b0;
    end else begin
      code_q     <= code_d;
      corr_q     <= nbr;
      inj_prev_q <= inj_en_i && !srst_i;
    end
  end

  assign state_o = cur_idx;
  assign code_o  = code_q;
  assign corr_o  = corr_q;

  AST_SRST_CLEARS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    srst_i |=> (code_q == RST_CODE)); // R2
  AST_CLEAN_WRITE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !inj_prev_q |-> !nbr); // R3
  AST_CORR_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    nbr |=> corr_o); // R5
  AST_CORR_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !nbr |=> !corr_o); // R5
  AST_JUMP_MIRROR: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (jump_i && !srst_i && !inj_en_i) |=> (state_o == ~$past(state_o))); // R6
  AST_ADV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (adv_i && !jump_i && !srst_i && !inj_en_i) |=> (state_o == idx_t'($past(state_o) + 1'b1))); // R7
  AST_REV_STEP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rev_i && !adv_i && !jump_i && !srst_i && !inj_en_i) |=> (state_o == idx_t'($past(state_o) - 1'b1))); // R8
  AST_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!rev_i && !adv_i && !jump_i && !srst_i && !inj_en_i) |=> $stable(state_o)); // R9
endmodule

// File: tb/secfsm_core_tb.sv
`timescale 1ns/1ps
module secfsm_core_tb;
  typedef struct packed {
    logic       srst;
    logic       jump;
    logic       adv;
    logic       rev;
    logic       inj;
    logic [6:0] mask;
    logic [3:0] exp;
  } vec_t;

  localparam int NV = 17;
  localparam vec_t VEC [NV] = '{
    '{1'b0,1'b0,1'b1,1'b0,1'b0,7'h00,4'd1},   // R7
    '{1'b0,1'b0,1'b1,1'b0,1'b0,7'h00,4'd2},   // R7
    '{1'b0,1'b0,1'b0,1'b1,1'b0,7'h00,4'd1},   // R8
    '{1'b0,1'b0,1'b1,1'b1,1'b0,7'h00,4'd2},   // R7 priority
    '{1'b0,1'b1,1'b1,1'b0,1'b0,7'h00,4'd13},  // R6
    '{1'b0,1'b0,1'b0,1'b0,1'b0,7'h00,4'd13},  // R9
    '{1'b0,1'b0,1'b1,1'b0,1'b1,7'h04,4'd14},  // R10
    '{1'b0,1'b0,1'b1,1'b0,1'b0,7'h00,4'd15},  // R4
    '{1'b0,1'b0,1'b1,1'b0,1'b0,7'h00,4'd0},   // R7 wrap
    '{1'b0,1'b0,1'b0,1'b1,1'b0,7'h00,4'd15},  // R8 wrap
    '{1'b0,1'b0,1'b0,1'b0,1'b1,7'h40,4'd15},  // R10
    '{1'b1,1'b1,1'b0,1'b0,1'b1,7'h01,4'd0},   // R2
    '{1'b0,1'b0,1'b0,1'b0,1'b0,7'h00,4'd0},   // R9
    '{1'b0,1'b0,1'b1,1'b0,1'b1,7'h00,4'd1},   // R10 zero mask
    '{1'b0,1'b1,1'b0,1'b0,1'b0,7'h00,4'd14},  // R6
    '{1'b0,1'b0,1'b0,1'b1,1'b1,7'h08,4'd13},  // R10
    '{1'b0,1'b1,1'b0,1'b0,1'b0,7'h00,4'd2}    // R4 R6
  };

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       srst_i = 1'b0, jump_i = 1'b0, adv_i = 1'b0, rev_i = 1'b0, inj_en_i = 1'b0;
  logic [6:0] inj_mask_i = '0;
  logic [3:0] state_o;
  logic [6:0] code_o;
  logic       corr_o;
  int total = 0;
  int bad = 0;
  logic dirty;

  always #2 clk_i = ~clk_i;

  secfsm_core u_dut (
    .clk_i, .rst_ni, .srst_i, .jump_i, .adv_i, .rev_i,
    .inj_en_i, .inj_mask_i, .state_o, .code_o, .corr_o
  );

  // generator rows taken from R3
  function automatic logic [6:0] enc(logic [3:0] d);
    logic [6:0] c = '0;
    if (d[0]) c ^= 7'b0000111;
    if (d[1]) c ^= 7'b0011001;
    if (d[2]) c ^= 7'b0101010;
    if (d[3]) c ^= 7'b1001011;
    return c;
  endfunction

  task automatic chk(string req, int act, int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s act=%0d exp=%0d", req, act, exp);
    end
  endtask

  task automatic drive(logic s, logic j, logic a, logic r, logic i, logic [6:0] m);
    srst_i = s; jump_i = j; adv_i = a; rev_i = r; inj_en_i = i; inj_mask_i = m;
    @(posedge clk_i);
    #1;
  endtask

  initial begin
    #(200000 * 4);
    bad++;
    $display("FAIL watchdog act=0 exp=1");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk_i);
    #1;
    chk("R1 code", int'(code_o), 0);
    chk("R1 state", int'(state_o), 0);
    chk("R1 corr", int'(corr_o), 0);
    rst_ni = 1'b1;

    dirty = 1'b0;
    for (int k = 0; k < NV; k++) begin
      logic [6:0] ec;
      drive(VEC[k].srst, VEC[k].jump, VEC[k].adv, VEC[k].rev, VEC[k].inj, VEC[k].mask);
      ec = VEC[k].srst ? 7'h00 : (enc(VEC[k].exp) ^ (VEC[k].inj ? VEC[k].mask : 7'h00));
      chk("R4/R6-R10 state", int'(state_o), int'(VEC[k].exp));
      chk("R3/R10 code", int'(code_o), int'(ec));
      chk("R5 corr", int'(corr_o), int'(dirty));
      dirty = !VEC[k].srst && VEC[k].inj && (VEC[k].mask != 0);
    end

    // R4 sweep: every state, every single bit
    drive(1'b1, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00);
    chk("R2 state", int'(state_o), 0);
    for (int s = 0; s < 16; s++) begin
      for (int b = 0; b < 7; b++) begin
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 7'(1 << b));
        chk("R4 decode", int'(state_o), s);
        drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00);
        chk("R5 pulse", int'(corr_o), 1);
        chk("R3 clean", int'(code_o), int'(enc(4'(s))));
      end
      drive(1'b0, 1'b0, 1'b1, 1'b0, 1'b0, 7'h00);
      chk("R5 single", int'(corr_o), 0);
      chk("R7 sweep", int'(state_o), (s + 1) % 16);
    end

    // R11 two-bit error from state 0
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b1, 7'b0000011);
    chk("R11 decode", int'(state_o), 1);
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00);
    chk("R11 rewrite", int'(code_o), int'(enc(4'd1)));
    chk("R5 corr", int'(corr_o), 1);

    // R1 async reset with a correction pending
    drive(1'b0, 1'b1, 1'b0, 1'b0, 1'b1, 7'h20);
    rst_ni = 1'b0;
    #1;
    chk("R1 async code", int'(code_o), 0);
    chk("R1 async state", int'(state_o), 0);
    chk("R1 async corr", int'(corr_o), 0);
    srst_i = 1'b0; jump_i = 1'b0; inj_en_i = 1'b0; inj_mask_i = '0;
    @(posedge clk_i);
    #1;
    rst_ni = 1'b1;
    drive(1'b0, 1'b0, 1'b0, 1'b0, 1'b0, 7'h00);
    chk("R1 after", int'(corr_o), 0);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule